// File: doc/BRIEF.md
# Extended Up/Down Position Counter with Coherent Snapshot

This block keeps a wide position count as two halves: a narrow low counter that steps by one on every enabled cycle, up or down according to a direction input, and an extension word that steps by one whenever the low counter rolls over. An upward rollover (all ones to zero) moves the extension word up and a downward rollover (zero to all ones) moves it down. By default the extension word takes each step one cycle after the rollover. This copies a system in which a slower agent keeps the upper word in step with the counter.

Because the two halves can disagree for a cycle, a read does not just join them. A read request first captures the extension word. On the next cycle it captures the low half, and on the cycle after that it looks at the extension word again. The top bit of the captured low half then picks which extension sample belongs with it. If the low half is in its upper range, the earlier of the two samples in count order is used. Otherwise the later one is used. The joined value comes out with a one-cycle valid strobe, so a read taken across a rollover still gives a value the counter really held.

A synchronous load presets the whole count, and reset clears it. Counting never stalls for a read.

Top module: `pos_ext_counter`

## Requirements
- R1: After reset the count is zero, `rd_valid` is low, and the first read returns 0.
- R2: On a clock edge with `cnt_en`=1 and `load_en`=0, the low half steps +1 when `cnt_up`=1 and -1 when `cnt_up`=0. With `cnt_en`=0 and `load_en`=0 it holds.
- R3: The extension word (bits 31..16 of the count) steps +1 after an upward rollover of the low half (0xFFFF to 0x0000) and -1 after a downward rollover (0x0000 to 0xFFFF). It does not change otherwise, except on a load. The extension word itself wraps modulo 2^16.
- R4: `load_en`=1 loads `load_val` into all 32 bits at the next edge. Load has priority over counting and cancels any extension step still pending from an earlier rollover.
- R5: A request (`rd_req`=1) accepted at edge k makes `rd_valid` high for exactly one cycle: the cycle that follows edge k+1. `rd_valid` is never high on two cycles in a row.
- R6: The value on `rd_value` while `rd_valid` is high equals the 32-bit count held in the cycle that follows the accepting edge k. This holds when a rollover falls anywhere in the read window, as long as the direction does not change during the window.
- R7: Selection rule: if the captured low half is 0x8000 or above, the extension sample that comes first in count order is used. Otherwise the one that comes later is used. The order is taken modulo 2^16, so reads across 0xFFFFFFFF/0x00000000 are correct.
- R8: A request on the cycle right after an accepted request is ignored and produces no strobe. A request on the cycle in which `rd_valid` is high is accepted as a new read.
- R9: Counting continues unchanged while a read is in progress. A read does not alter the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Step the count on this edge |
| cnt_up | input | 1 | Direction: 1 counts up, 0 counts down |
| load_en | input | 1 | Preset the whole count from `load_val` |
| load_val | input | 32 | Preset value |
| rd_req | input | 1 | Start a coherent read |
| rd_valid | output | 1 | One-cycle strobe marking `rd_value` |
| rd_value | output | 32 | Reconciled count; zero when `rd_valid` is low |

## Verification
A read is due two cycles after its request. The request is accepted at edge k, and the strobe and value are visible after edge k+1. The expected value is the bench model's count right after edge k. The count and the next state of the bench model change at each rising edge. The bench drives inputs and samples outputs on falling edges, so every check falls in a known cycle: it expects no strobe in the cycle after acceptance, a strobe in the next one, and none after an ignored request. Rollovers are placed at each offset within the read window in both directions and across the top of the 32-bit range.

// File: rtl/pos_ext_pkg.sv
package pos_ext_pkg;

   // Read sequencer states
   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_HAVE_A = 2'd1,
      RD_HAVE_B = 2'd2
   } rd_state_e;

endpackage

// File: rtl/pos_low_half.sv
module pos_low_half #(
   parameter int LO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  logic            step_up,
   input  logic            load_en,
   input  logic [LO_W-1:0] load_lo,
   output logic [LO_W-1:0] lo_q,
   output logic            wrap_up,
   output logic            wrap_dn
);

   localparam logic [LO_W-1:0] LO_MAX  = {LO_W{1'b1}};
   localparam logic [LO_W-1:0] LO_ZERO = '0;
   localparam logic [LO_W-1:0] LO_ONE  = LO_W'(1);

   logic do_step;

   assign do_step = step_en && !load_en;
   // rollover happens on the edge that moves past the end of the range
   assign wrap_up = do_step &&  step_up && (lo_q == LO_MAX);
   assign wrap_dn = do_step && !step_up && (lo_q == LO_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (load_en) begin
         lo_q <= load_lo;
      end else if (do_step) begin
         if (step_up) lo_q <= lo_q + LO_ONE;
         else         lo_q <= lo_q - LO_ONE;
      end
   end

endmodule

// File: rtl/pos_ext_word.sv
module pos_ext_word #(
   parameter int HI_W      = 16,
   parameter int EXT_DELAY = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wrap_up,
   input  logic            wrap_dn,
   input  logic            load_en,
   input  logic [HI_W-1:0] load_hi,
   output logic [HI_W-1:0] hi_q
);

   localparam logic [HI_W-1:0] HI_ONE = HI_W'(1);

   logic inc_now;
   logic dec_now;

   generate
      if (EXT_DELAY != 0) begin : g_delayed
         // rollover events are held for one cycle before they reach the word
         logic pend_up_q;
         logic pend_dn_q;
         always_ff @(posedge clk) begin
            if (!rst_n || load_en) begin
               pend_up_q <= 1'b0;
               pend_dn_q <= 1'b0;
            end else begin
               pend_up_q <= wrap_up;
               pend_dn_q <= wrap_dn;
            end
         end
         assign inc_now = pend_up_q;
         assign dec_now = pend_dn_q;
      end else begin : g_direct
         assign inc_now = wrap_up;
         assign dec_now = wrap_dn;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
      end else if (load_en) begin
         hi_q <= load_hi;
      end else if (inc_now && !dec_now) begin
         hi_q <= hi_q + HI_ONE;
      end else if (dec_now && !inc_now) begin
         hi_q <= hi_q - HI_ONE;
      end
   end

endmodule

// File: rtl/pos_snap_reconcile.sv
module pos_snap_reconcile
   import pos_ext_pkg::*;
#(
   parameter int LO_W = 16,
   parameter int HI_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_req,
   input  logic [HI_W-1:0]      hi_live,
   input  logic [LO_W-1:0]      lo_live,
   output logic                 rd_valid,
   output logic [LO_W+HI_W-1:0] rd_value
);

   localparam logic [HI_W-1:0] HI_ONE = HI_W'(1);

   rd_state_e       state_q;
   logic [HI_W-1:0] a_q;     // first extension sample
   logic [LO_W-1:0] b_q;     // low half sample
   logic [HI_W-1:0] c_w;     // second extension sample, taken live
   logic [HI_W-1:0] hi_sel;

   // with at most one step between samples, c one past a marks a forward order
   function automatic logic [HI_W-1:0] pick_hi(
      input logic [HI_W-1:0] first_s,
      input logic [HI_W-1:0] second_s,
      input logic            upper_range
   );
      logic fwd;
      fwd = (second_s == first_s + HI_ONE);
      if (first_s == second_s) return first_s;
      if (upper_range)         return fwd ? first_s  : second_s;
      return                          fwd ? second_s : first_s;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         a_q     <= '0;
         b_q     <= '0;
      end else begin
         unique case (state_q)
            RD_IDLE: begin
               if (rd_req) begin
                  a_q     <= hi_live;
                  state_q <= RD_HAVE_A;
               end
            end
            RD_HAVE_A: begin
               b_q     <= lo_live;
               state_q <= RD_HAVE_B;
            end
            RD_HAVE_B: begin
               if (rd_req) begin
                  a_q     <= hi_live;
                  state_q <= RD_HAVE_A;
               end else begin
                  state_q <= RD_IDLE;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign c_w      = hi_live;
   assign hi_sel   = pick_hi(a_q, c_w, b_q[LO_W-1]);
   assign rd_valid = (state_q == RD_HAVE_B);
   assign rd_value = rd_valid ? {hi_sel, b_q} : '0;

endmodule

// File: rtl/pos_ext_counter.sv
module pos_ext_counter #(
   parameter int LO_W      = 16,
   parameter int HI_W      = 16,
   parameter int EXT_DELAY = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cnt_en,
   input  logic                 cnt_up,
   input  logic                 load_en,
   input  logic [LO_W+HI_W-1:0] load_val,
   input  logic                 rd_req,
   output logic                 rd_valid,
   output logic [LO_W+HI_W-1:0] rd_value
);

   localparam int CNT_W = LO_W + HI_W;

   generate
      if (LO_W < 2) begin : g_bad_lo
         $error("pos_ext_counter: LO_W must be at least 2");
      end
      if (HI_W < 1) begin : g_bad_hi
         $error("pos_ext_counter: HI_W must be at least 1");
      end
      if (EXT_DELAY != 0 && EXT_DELAY != 1) begin : g_bad_dly
         $error("pos_ext_counter: EXT_DELAY must be 0 or 1");
      end
   endgenerate

   logic [LO_W-1:0] lo_q;
   logic [HI_W-1:0] hi_q;
   logic            wrap_up;
   logic            wrap_dn;

   pos_low_half #(.LO_W(LO_W)) low_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (cnt_en),
      .step_up (cnt_up),
      .load_en (load_en),
      .load_lo (load_val[LO_W-1:0]),
      .lo_q    (lo_q),
      .wrap_up (wrap_up),
      .wrap_dn (wrap_dn)
   );

   pos_ext_word #(.HI_W(HI_W), .EXT_DELAY(EXT_DELAY)) ext_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_up (wrap_up),
      .wrap_dn (wrap_dn),
      .load_en (load_en),
      .load_hi (load_val[CNT_W-1:LO_W]),
      .hi_q    (hi_q)
   );

   pos_snap_reconcile #(.LO_W(LO_W), .HI_W(HI_W)) snap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .hi_live  (hi_q),
      .lo_live  (lo_q),
      .rd_valid (rd_valid),
      .rd_value (rd_value)
   );

endmodule

// File: rtl/pos_ext_counter_chk.sv
module pos_ext_counter_chk #(
   parameter int LO_W = 16,
   parameter int HI_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cnt_en,
   input logic                 cnt_up,
   input logic                 load_en,
   input logic [LO_W+HI_W-1:0] load_val,
   input logic                 rd_req,
   input logic                 rd_valid,
   input logic [LO_W-1:0]      lo_q,
   input logic [HI_W-1:0]      hi_q
);

   a_r2_low_up: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && cnt_up && !load_en) |=> (lo_q == LO_W'($past(lo_q) + 1'b1)));

   a_r2_low_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !cnt_up && !load_en) |=> (lo_q == LO_W'($past(lo_q) - 1'b1)));

   a_r2_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load_en) |=> $stable(lo_q));

   a_r3_ext_step: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> (hi_q == $past(hi_q) ||
                    hi_q == HI_W'($past(hi_q) + 1'b1) ||
                    hi_q == HI_W'($past(hi_q) - 1'b1)));

   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> ({hi_q, lo_q} == $past(load_val)));

   a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   a_r5_strobe_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req, 2));

endmodule

bind pos_ext_counter pos_ext_counter_chk #(.LO_W(LO_W), .HI_W(HI_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_en   (cnt_en),
   .cnt_up   (cnt_up),
   .load_en  (load_en),
   .load_val (load_val),
   .rd_req   (rd_req),
   .rd_valid (rd_valid),
   .lo_q     (lo_q),
   .hi_q     (hi_q)
);

// File: tb/pos_ext_counter_tb_top.sv
`timescale 1ns/1ps
module pos_ext_counter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        cnt_up = 1'b0;
   logic        load_en = 1'b0;
   logic [31:0] load_val = '0;
   logic        rd_req = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_value;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;
   logic [31:0] m = '0;   // bench model of the count

   always #2.5 clk = ~clk;

   pos_ext_counter dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
      .load_en(load_en), .load_val(load_val), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_value(rd_value)
   );

   function automatic logic [31:0] next_count(input logic [31:0] cur, input bit en,
                                              input bit up, input bit ld,
                                              input logic [31:0] lv);
      if (ld) return lv;
      if (en) return up ? cur + 32'd1 : cur - 32'd1;
      return cur;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at falling edge, advance model at rising edge, return at falling edge
   task automatic cyc(input bit en, input bit up, input bit ld, input logic [31:0] lv,
                      input bit req);
      cnt_en = en; cnt_up = up; load_en = ld; load_val = lv; rd_req = req;
      @(posedge clk);
      m = next_count(m, en, up, ld, lv);
      @(negedge clk);
   endtask

   // coherent read: request at edge k, value expected after edge k+1
   task automatic do_read(input bit up, input bit en0, input bit en1, input string tag);
      logic [31:0] exp;
      cyc(en0, up, 1'b0, '0, 1'b1);
      exp = m;
      check(rd_valid == 1'b0, {"R5 no early strobe ", tag}, {31'd0, rd_valid}, 32'd0);
      cyc(en1, up, 1'b0, '0, 1'b0);
      check(rd_valid == 1'b1, {"R5 strobe ", tag}, {31'd0, rd_valid}, 32'd1);
      check(rd_value == exp, {"R6 R7 value ", tag}, rd_value, exp);
   endtask

   task automatic idle(input int n, input bit en, input bit up);
      for (int i = 0; i < n; i++) cyc(en, up, 1'b0, '0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] exp;
      void'($urandom(32'h5eed_0042));
      @(negedge clk);
      idle(3, 1'b0, 1'b1);
      check(rd_valid == 1'b0, "R1 valid low in reset", {31'd0, rd_valid}, 32'd0);
      rst_n = 1'b1;
      m = '0;
      idle(1, 1'b0, 1'b1);
      do_read(1'b1, 1'b0, 1'b0, "R1 reset value");

      // R2 up, hold, down through zero (R3 downward rollover)
      idle(5, 1'b1, 1'b1);
      do_read(1'b1, 1'b0, 1'b0, "R2 up by five");
      idle(3, 1'b0, 1'b0);
      do_read(1'b0, 1'b0, 1'b0, "R2 hold");
      idle(7, 1'b1, 1'b0);
      do_read(1'b0, 1'b0, 1'b0, "R3 down past zero");
      check(m == 32'hFFFF_FFFE, "R3 model sanity", m, 32'hFFFF_FFFE);

      // R7 rollover at each position within the read window, both directions
      for (int off = 0; off < 6; off++) begin
         cyc(1'b0, 1'b1, 1'b1, 32'h0003_FFFE - 32'(off), 1'b0);
         idle(2, 1'b1, 1'b1);
         do_read(1'b1, 1'b1, 1'b1, "R7 up wrap window");
         idle(1, 1'b0, 1'b1);
         do_read(1'b1, 1'b0, 1'b0, "R3 up wrap settled");
         cyc(1'b0, 1'b0, 1'b1, 32'h0005_0001 + 32'(off), 1'b0);
         idle(2, 1'b1, 1'b0);
         do_read(1'b0, 1'b1, 1'b1, "R7 down wrap window");
         idle(1, 1'b0, 1'b0);
         do_read(1'b0, 1'b0, 1'b0, "R3 down wrap settled");
      end

      // R7 extension word wraps modulo 2^16
      cyc(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFD, 1'b0);
      for (int i = 0; i < 4; i++) begin
         idle(1, 1'b1, 1'b1);
         do_read(1'b1, 1'b1, 1'b1, "R7 top of range up");
      end
      cyc(1'b0, 1'b0, 1'b1, 32'h0000_0002, 1'b0);
      for (int i = 0; i < 4; i++) begin
         idle(1, 1'b1, 1'b0);
         do_read(1'b0, 1'b1, 1'b1, "R7 bottom of range down");
      end

      // R4 load beats count, and cancels a pending extension step
      cyc(1'b1, 1'b1, 1'b1, 32'hA5A5_1234, 1'b0);
      do_read(1'b1, 1'b0, 1'b0, "R4 load priority");
      cyc(1'b0, 1'b1, 1'b1, 32'h0000_FFFF, 1'b0);
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 32'h1234_0000, 1'b0);
      idle(3, 1'b0, 1'b1);
      do_read(1'b1, 1'b0, 1'b0, "R4 pending step cancelled");

      // R8 request in the cycle after acceptance is ignored
      cyc(1'b0, 1'b1, 1'b1, 32'h0000_0100, 1'b0);
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b1);
      exp = m;
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b1);
      check(rd_valid && rd_value == exp, "R8 first read value", rd_value, exp);
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
      check(rd_valid == 1'b0, "R8 ignored request gives no strobe", {31'd0, rd_valid}, 32'd0);
      idle(2, 1'b0, 1'b1);

      // R8 request in the strobe cycle is accepted back to back; R9 counting continues
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b1);
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
      check(rd_valid == 1'b1, "R8 first of pair", {31'd0, rd_valid}, 32'd1);
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b1);
      exp = m;
      cyc(1'b1, 1'b1, 1'b0, '0, 1'b0);
      check(rd_valid && rd_value == exp, "R8 back to back read", rd_value, exp);
      idle(1, 1'b0, 1'b1);
      do_read(1'b1, 1'b0, 1'b0, "R9 count continued through reads");

      // constrained random segments
      for (int s = 0; s < 1500; s++) begin
         bit          up;
         logic [31:0] lv;
         up = 1'($urandom);
         if ($urandom % 3 == 0) begin
            case ($urandom % 4)
               0: lv = $urandom;
               1: lv = {16'($urandom), 16'hFFFF - 16'($urandom % 4)};
               2: lv = {16'($urandom), 16'($urandom % 4)};
               default: lv = (up ? 32'hFFFF_FFFF : 32'd0) + 32'($urandom % 8) - 32'd4;
            endcase
            cyc(1'b0, up, 1'b1, lv, 1'b0);
         end
         for (int i = 0; i < 2 + int'($urandom % 4); i++)
            cyc(($urandom % 4) != 0, up, 1'b0, '0, 1'b0);
         do_read(up, ($urandom % 4) != 0, ($urandom % 4) != 0, "R6 random");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule